// File: doc/BRIEF.md
# Prescaled Seconds Timer with Alarm

This block is a free-running time base for an always-on power domain. A prescaler counts cycles of a slow input clock, and each time it completes a programmed number of them it advances a 32-bit up-counter by one. A common use is to load the prescaler with the input frequency so that the counter ticks once a second. Software reads the counter over a small 32-bit register bus. It cannot load the counter, but it can restart both the prescaler and the counter from zero.

A 32-bit compare register raises an alarm flag when the counter steps onto its value. A second flag is set on every counter step. Both flags sit in a status register that clears when it is read. Each flag has its own enable bit in the mode register, and together they drive one interrupt line. After reset the compare register holds all ones, which software treats as "no alarm armed".

Register words are selected by address bits 3:2: mode at 0x0, compare at 0x4, counter at 0x8, status at 0xC. A read returns data in the same cycle it is presented. Writes and status-clearing reads take effect at the clock edge that ends the bus cycle.

Top module: `tick_timer`

## Requirements
- R1: After reset, mode reads 0x00008000, compare reads 0xFFFFFFFF, counter reads 0, status reads 0 and `irq` is low.
- R2: The counter goes up by one each time the prescaler has seen N input clocks, where N is mode bits 15:0. A reload of 0 gives N = 65536.
- R3: Writing mode with bit 18 set clears both the prescaler and the counter at that edge. Bit 18 is not stored and always reads back as 0.
- R4: Writes to the counter word (0x8) and the status word (0xC) change no state.
- R5: The compare word (0x4) stores and returns all 32 written bits.
- R6: Status bit 0 (alarm) is set on the edge where the counter steps to a value equal to the compare word. It stays set until the status word is read.
- R7: Status bit 1 (increment) is set on every counter step.
- R8: Reading the status word returns both flags and clears them at that edge. A flag event in the same cycle as the read wins, and that flag stays set.
- R9: `irq` is high exactly when (status bits 1:0 AND mode bits 17:16) is nonzero. Mode bit 16 enables the alarm flag and bit 17 enables the increment flag.
- R10: Mode bits 15:0 and 17:16 read back as written, and all other mode bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow input clock that the prescaler counts |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address; bits 3:2 select the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as the read; 0 when no read is active |
| irq | output | 1 | Flags that are set and enabled |

## Verification
The assertions assume that the bus signals are stable at each clock edge and that an access lasts exactly one cycle. They also assume that the prescaler reload only changes in the same write that restarts the timer. If it changed on its own, the running prescaler could lie past the new terminal count and wrap through its whole range. The stimulus follows these rules: every access is driven on the falling edge and released one cycle later, and every new reload value is written together with bit 18. Enable-only writes keep the reload that is already loaded.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int BUS_W = 32;

  // word select taken from address bits 3:2
  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_ALARM  = 2'd1,
    SEL_VALUE  = 2'd2,
    SEL_STATUS = 2'd3
  } word_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
  } ctl_strobe_t;

  // events from datapath to control
  typedef struct packed {
    logic step;
    logic hit;
  } dp_event_t;

endpackage

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobe_t      strobe,
  input  logic [PRE_W-1:0] reloadVal,
  input  logic [CNT_W-1:0] alarmVal,
  output logic [CNT_W-1:0] cntValue,
  output dp_event_t        ev
);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] lastTap;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;
  logic             stepNow;

  // reload 0 wraps to all ones, which gives a full 2^PRE_W period
  assign lastTap = reloadVal - PRE_W'(1);
  assign stepNow = !strobe.restart && (preCnt == lastTap);
  assign cntNext = cntQ + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      cntQ   <= '0;
    end else if (strobe.restart) begin
      preCnt <= '0;
      cntQ   <= '0;
    end else if (stepNow) begin
      preCnt <= '0;
      cntQ   <= cntNext;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  assign cntValue = cntQ;
  assign ev.step  = stepNow;
  assign ev.hit   = stepNow && (cntNext == alarmVal);

endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int PRE_W  = 16,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  dp_event_t         ev,
  input  logic [CNT_W-1:0]  cntValue,
  output ctl_strobe_t       strobe,
  output logic [PRE_W-1:0]  reloadVal,
  output logic [CNT_W-1:0]  alarmVal,
  output logic [1:0]        intEn,
  output logic [1:0]        flagsQ,
  output logic              irq
);

  localparam int EN_LSB  = PRE_W;
  localparam int RST_BIT = PRE_W + 2;
  localparam logic [PRE_W-1:0] RELOAD_RST = PRE_W'(1) << (PRE_W - 1);

  word_sel_e  wordSel;
  logic       wrMode;
  logic       wrAlarm;
  logic       statusRd;
  logic [1:0] setVec;
  logic       unusedBits;

  assign wordSel  = word_sel_e'(busAddr[3:2]);
  assign wrMode   = busSel && busWr && (wordSel == SEL_MODE);
  assign wrAlarm  = busSel && busWr && (wordSel == SEL_ALARM);
  assign statusRd = busSel && !busWr && (wordSel == SEL_STATUS);
  assign unusedBits = ^{busAddr[1:0], busAddr[ADDR_W-1:2], busWdata};

  assign strobe.restart = wrMode && busWdata[RST_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= RELOAD_RST;
      intEn     <= 2'b00;
    end else if (wrMode) begin
      reloadVal <= busWdata[PRE_W-1:0];
      intEn     <= busWdata[EN_LSB+1:EN_LSB];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmVal <= '1;
    end else if (wrAlarm) begin
      alarmVal <= busWdata[CNT_W-1:0];
    end
  end

  // bit 0 alarm, bit 1 increment; an event beats a clearing read
  assign setVec = {ev.step, ev.hit};

  for (genvar i = 0; i < 2; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagsQ[i] <= 1'b0;
      end else if (setVec[i]) begin
        flagsQ[i] <= 1'b1;
      end else if (statusRd) begin
        flagsQ[i] <= 1'b0;
      end
    end
  end

  assign irq = |(flagsQ & intEn);

  always_comb begin
    busRdata = '0;
    if (busSel && !busWr) begin
      case (wordSel)
        SEL_MODE: begin
          busRdata[PRE_W-1:0]         = reloadVal;
          busRdata[EN_LSB+1:EN_LSB]   = intEn;
        end
        SEL_ALARM:  busRdata[CNT_W-1:0] = alarmVal;
        SEL_VALUE:  busRdata[CNT_W-1:0] = cntValue;
        SEL_STATUS: busRdata[1:0]       = flagsQ;
        default:    busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int PRE_W  = 16,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq
);

  ctl_strobe_t      strobe;
  dp_event_t        dpEv;
  logic [PRE_W-1:0] reloadVal;
  logic [CNT_W-1:0] alarmVal;
  logic [CNT_W-1:0] cntValue;
  logic [1:0]       intEn;
  logic [1:0]       flagsQ;
  logic             stepEv;

  assign stepEv = dpEv.step;

  tick_timer_ctrl #(
    .PRE_W(PRE_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .ev(dpEv), .cntValue(cntValue),
    .strobe(strobe), .reloadVal(reloadVal), .alarmVal(alarmVal),
    .intEn(intEn), .flagsQ(flagsQ), .irq(irq)
  );

  tick_timer_dp #(
    .PRE_W(PRE_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .reloadVal(reloadVal), .alarmVal(alarmVal),
    .cntValue(cntValue), .ev(dpEv)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int PRE_W  = 16,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [CNT_W-1:0]  cntValue,
  input logic [1:0]        flags,
  input logic [1:0]        intEn,
  input logic              stepNow,
  input logic              irq
);

  logic restartReq;
  logic statusRd;

  assign restartReq = busSel && busWr && (busAddr[3:2] == 2'd0) && busWdata[PRE_W+2];
  assign statusRd   = busSel && !busWr && (busAddr[3:2] == 2'd3);

  // R3
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> (cntValue == '0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepNow |=> (cntValue == CNT_W'($past(cntValue) + CNT_W'(1))));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stepNow && !restartReq) |=> $stable(cntValue));

  // R7
  inc_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepNow |=> flags[1]);

  // R8
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !stepNow) |=> (flags == 2'b00));

  // R6
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && !statusRd) |=> flags[0]);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((flags == 2'b00) || (intEn == 2'b00)) |-> !irq);

endmodule

bind tick_timer tick_timer_chk #(
  .PRE_W(PRE_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .busAddr(busAddr), .busWdata(busWdata), .cntValue(cntValue),
  .flags(flagsQ), .intEn(intEn), .stepNow(stepEv), .irq(irq)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int testsRun = 0;
  int testsFailed = 0;
  bit running = 1'b0;

  // reference model state
  int unsigned mReload;
  int unsigned mPre;
  logic [1:0]  mEn;
  logic [31:0] mAlarm;
  logic [31:0] mCnt;
  logic [1:0]  mFlags;
  bit          mRestart, mStep, mHit, mRdStat;
  int unsigned mPeriod;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mReload = 32'h8000; mPre = 0; mEn = 2'b00;
      mAlarm = 32'hFFFF_FFFF; mCnt = 0; mFlags = 2'b00;
    end else begin
      mRestart = busSel && busWr && (busAddr[3:2] == 2'd0) && busWdata[18];
      mRdStat  = busSel && !busWr && (busAddr[3:2] == 2'd3);
      mPeriod  = (mReload == 0) ? 65536 : mReload;
      mStep    = !mRestart && (mPre + 1 == mPeriod);
      mHit     = mStep && (mCnt + 32'd1 == mAlarm);
      if (mRdStat) mFlags = 2'b00;
      if (mStep) mFlags[1] = 1'b1;
      if (mHit) mFlags[0] = 1'b1;
      if (mRestart) begin
        mPre = 0; mCnt = 0;
      end else if (mStep) begin
        mPre = 0; mCnt = mCnt + 32'd1;
      end else begin
        mPre = mPre + 1;
      end
      if (busSel && busWr && busAddr[3:2] == 2'd0) begin
        mReload = busWdata[15:0]; mEn = busWdata[17:16];
      end
      if (busSel && busWr && busAddr[3:2] == 2'd1) mAlarm = busWdata;
    end
  end

  function automatic logic [31:0] expRead(input logic [3:0] a);
    case (a[3:2])
      2'd0: return {14'b0, mEn, mReload[15:0]};
      2'd1: return mAlarm;
      2'd2: return mCnt;
      default: return {30'b0, mFlags};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // R9: interrupt compared with the model on every cycle
  always @(negedge clk) begin
    if (running) check("R9 irq", {31'b0, irq}, {31'b0, |(mFlags & mEn)});
  end

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [3:0] a, input string tag);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 check(tag, busRdata, expRead(a));
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic busReadK(input logic [3:0] a, input string tag, input logic [31:0] k);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 check(tag, busRdata, k);
    check({tag, " model"}, busRdata, expRead(a));
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;

    // R1 reset values
    check("R1 irq", {31'b0, irq}, 32'd0);
    busReadK(4'h0, "R1 mode", 32'h0000_8000);
    busReadK(4'h4, "R1 alarm", 32'hFFFF_FFFF);
    busReadK(4'h8, "R1 value", 32'd0);
    busReadK(4'hC, "R1 status", 32'd0);

    // R3 / R10 restart with reload 4, both enables
    busWrite(4'h0, 32'h0007_0004);
    busReadK(4'h0, "R3 R10 mode readback", 32'h0003_0004);
    idle(9);
    busRead(4'h8, "R2 value reload 4");
    busRead(4'hC, "R7 status");
    idle(6);
    busRead(4'h8, "R2 value later");

    // R4 writes to counter and status ignored
    busWrite(4'h8, 32'hDEAD_BEEF);
    busWrite(4'hC, 32'h0000_0003);
    busRead(4'h8, "R4 value after write");
    busRead(4'hC, "R4 status after write");

    // R5 compare storage
    busWrite(4'h4, 32'h1234_5678);
    busReadK(4'h4, "R5 alarm readback", 32'h1234_5678);

    // R6 alarm at count 3
    busWrite(4'h4, 32'd3);
    busWrite(4'h0, 32'h0007_0004);
    busRead(4'hC, "R8 clear before alarm");
    idle(14);
    busRead(4'hC, "R6 alarm flag");
    busRead(4'hC, "R6 R8 cleared after read");

    // R9 enables off: flags set, irq low
    busWrite(4'h0, 32'h0000_0004);
    idle(10);
    check("R9 masked irq", {31'b0, irq}, 32'd0);
    busRead(4'hC, "R9 status with mask");

    // R8 read coincident with step every cycle
    busWrite(4'h0, 32'h0006_0001);
    busRead(4'hC, "R8 read during step");
    busRead(4'hC, "R8 flag survives read");
    busRead(4'h8, "R2 value reload 1");

    // R2 reload 0 means 65536
    busWrite(4'h0, 32'h0004_0000);
    idle(65533);
    busReadK(4'h8, "R2 before full period", 32'd0);
    busReadK(4'h8, "R2 after full period", 32'd1);
    busRead(4'hC, "R7 status after long period");

    idle(2);
    running = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule